// File: doc/BRIEF.md
# Multi-cycle accumulator processor

This block is a tiny 8-bit processor that runs from its clock and a synchronous reset alone. It has no other inputs. A reset copies a program image into a 32-byte on-chip RAM and clears every register. The machine then fetches, decodes and executes one instruction after another, forever. Only three operations exist: copy a memory byte into the accumulator, add a memory byte to the accumulator, and write the accumulator back to memory.

Each instruction takes a fixed run of register-transfer steps. First the program counter passes through a mux into the memory address register. Next the RAM byte at that address moves into the memory data register. Then the instruction register captures the word while the program counter steps forward. A valid instruction next puts its operand address into the address register and uses the RAM in the following cycle. The accumulator, the instruction register and the program counter are brought out so the program can be watched as it runs.

The top three bits of an instruction give the opcode and the low five bits give the operand address. There are no jumps, so the program counter simply wraps from 31 back to 0. Data bytes are then executed as instructions as well.

Top module: `acc_cpu`

## Requirements
- R1: The program counter output starts at 0, rises by exactly one (modulo 32) once per instruction, and never changes in any other way outside reset.
- R2: The instruction output changes only in the cycle in which the program counter steps. Its new value is the RAM byte stored at the address the program counter held just before that step.
- R3: Opcode 000 (bits 7:5) sets the accumulator to the RAM byte at the operand address held in bits 4:0.
- R4: Opcode 001 sets the accumulator to the accumulator plus the RAM byte at the operand address, modulo 256. The carry is dropped.
- R5: Opcode 010 writes the accumulator into RAM at the operand address and leaves the accumulator unchanged. A later load from that address returns the stored value.
- R6: Opcodes 011 through 111 change neither the accumulator nor the RAM. The next program counter step comes 3 cycles after the step that fetched them.
- R7: After the program counter step that fetches a valid opcode, the next step comes exactly 5 cycles later. The accumulator changes only in cycles where the program counter holds still.
- R8: While reset is high, the program counter, the accumulator and the instruction register read 0, and the RAM is reloaded from the PROG parameter (byte i taken from bits 8i+7 down to 8i). After release, fetching restarts at address 0 and the first program counter step comes on the third clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| acc_o | output | 8 | Accumulator value |
| ir_o | output | 8 | Instruction register value |
| pc_o | output | 5 | Program counter value |

## Verification
A wrong internal state shows up at the ports within one instruction. If the sequencer skips or repeats a state, the gap between program counter steps no longer matches 3 or 5 cycles, and that mismatch is visible at the very next step. A bad operand address, a wrong ALU operation or a missed RAM write shows up in the accumulator. For a load or add, the error is visible when the next instruction is fetched. For a store, it appears at the first later load of that location, which the test program places a few instructions afterwards. The program also runs past the end of its code into the data area and wraps the program counter twice. As a result, stored bytes are later executed as instructions, which exposes RAM corruption through the instruction output as well.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW = 8,
  parameter int AW = 5,
  parameter logic [(1<<AW)*DW-1:0] PROG =
    256'h0000_0000_0000_0000_0000_0000_80FF_0A05_6060_6060_6016_5633_1555_3214_E054_3110
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] ir_o,
  output logic [AW-1:0] pc_o
);
  localparam int DEPTH = 1 << AW;
  localparam int OPW   = DW - AW;
  localparam logic [OPW-1:0] OP_LD  = OPW'(0);
  localparam logic [OPW-1:0] OP_ADD = OPW'(1);
  localparam logic [OPW-1:0] OP_ST  = OPW'(2);

  typedef enum logic [2:0] {S_FA, S_FR, S_DEC, S_EXA, S_EXM} state_t;

  state_t        state, state_n;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mdr, ir, acc;
  logic [DW-1:0] ram [DEPTH];

  wire [OPW-1:0] dec_op = mdr[DW-1 -: OPW];
  wire [OPW-1:0] ex_op  = ir[DW-1 -: OPW];
  wire           dec_ok = dec_op <= OP_ST;

  wire           ld_mar = (state == S_FA) || (state == S_EXA);
  wire [AW-1:0]  mar_d  = (state == S_FA) ? pc : ir[AW-1:0];
  wire           ld_mdr = (state == S_FR) || (state == S_EXM && ex_op != OP_ST);
  wire           ld_ir  = state == S_DEC;
  wire           ld_acc = (state == S_EXM) && (ex_op == OP_LD || ex_op == OP_ADD);
  wire           ram_we = (state == S_EXM) && (ex_op == OP_ST);

  wire [DW-1:0]  ram_q  = ram[mar];
  wire [DW-1:0]  alu_y  = (ex_op == OP_ADD) ? acc + ram_q : ram_q;

  always_comb begin
    case (state)
      S_FA:    state_n = S_FR;
      S_FR:    state_n = S_DEC;
      S_DEC:   state_n = dec_ok ? S_EXA : S_FA;
      S_EXA:   state_n = S_EXM;
      default: state_n = S_FA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FA;
      pc    <= '0;
      mar   <= '0;
      mdr   <= '0;
      ir    <= '0;
      acc   <= '0;
      for (int i = 0; i < DEPTH; i++) ram[i] <= PROG[i*DW +: DW];
    end else begin
      state <= state_n;
      if (ld_mar) mar <= mar_d;
      if (ld_mdr) mdr <= ram_q;
      if (ld_ir) begin
        ir <= mdr;
        pc <= pc + 1'b1;
      end
      if (ld_acc) acc <= alu_y;
      if (ram_we) ram[mar] <= acc;
    end
  end

  assign acc_o = acc;
  assign ir_o  = ir;
  assign pc_o  = pc;
endmodule

module acc_cpu_chk #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] acc,
  input logic [DW-1:0] ir,
  input logic [AW-1:0] pc,
  input logic [2:0]    state
);
  logic          seen;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] ir_q, acc_q;
  logic [3:0]    gap;

  always_ff @(posedge clk) begin
    seen  <= !rst;
    pc_q  <= pc;
    ir_q  <= ir;
    acc_q <= acc;
    if (rst) gap <= '0;
    else if (seen && pc != pc_q) gap <= 4'd1;
    else if (gap != 4'hF) gap <= gap + 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pc == '0 && acc == '0 && ir == '0)); // R8
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (seen && pc != pc_q) |-> pc == pc_q + 1'b1); // R1
  AST_IR_WITH_PC: assert property (@(posedge clk) disable iff (rst)
    (seen && ir != ir_q) |-> pc != pc_q); // R2
  AST_ACC_QUIET_STEP: assert property (@(posedge clk) disable iff (rst)
    (seen && acc != acc_q) |-> pc == pc_q); // R7
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state <= 3'd4); // R7
  AST_INSTR_LEN: assert property (@(posedge clk) disable iff (rst)
    gap <= 4'd6); // R6
endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .acc(acc), .ir(ir), .pc(pc), .state(state)
);

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  localparam logic [255:0] IMG =
    256'h0000_0000_0000_0000_0000_0000_80FF_0A05_6060_6060_6016_5633_1555_3214_E054_3110;

  typedef struct packed {
    logic [4:0] pc;
    logic [7:0] ir;
    logic [7:0] acc;
    int         gap;
    logic [3:0] prev;
  } item_t;

  logic clk = 0, rst = 1;
  logic [7:0] acc_o, ir_o;
  logic [4:0] pc_o;
  int checks = 0, errors = 0;
  item_t sb[$];

  always #10 clk = ~clk;

  acc_cpu #(.DW(8), .AW(5), .PROG(IMG)) u_acc_cpu (
    .clk(clk), .rst(rst), .acc_o(acc_o), .ir_o(ir_o), .pc_o(pc_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_model(int n);
    logic [7:0] mem [32];
    logic [7:0] a = 0;
    logic [4:0] p = 0;
    int len = 3;
    logic [3:0] prev = 4'd8;
    for (int i = 0; i < 32; i++) mem[i] = IMG[i*8 +: 8];
    for (int k = 0; k < n; k++) begin
      item_t it;
      logic [7:0] w;
      w = mem[p];
      it.pc = p + 5'd1; it.ir = w; it.acc = a; it.gap = len; it.prev = prev;
      sb.push_back(it);
      case (w[7:5])
        3'd0: a = mem[w[4:0]];
        3'd1: a = a + mem[w[4:0]];
        3'd2: mem[w[4:0]] = a;
        default: ;
      endcase
      len  = (w[7:5] <= 3'd2) ? 5 : 3;
      prev = {1'b0, w[7:5]};
      p    = p + 5'd1;
    end
  endtask

  function automatic string acc_tag(logic [3:0] prev);
    case (prev)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd8: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic monitor(int n);
    logic [4:0] last = pc_o;
    for (int k = 0; k < n; k++) begin
      int cnt = 0;
      item_t it;
      do begin
        @(negedge clk);
        cnt++;
      end while (pc_o == last && cnt < 12);
      it = sb.pop_front();
      chk("R1", pc_o, it.pc);
      chk("R2", ir_o, it.ir);
      chk(acc_tag(it.prev), acc_o, it.acc);
      chk((it.prev >= 4'd3 && it.prev <= 4'd7) ? "R6" : "R7", cnt, it.gap);
      last = pc_o;
    end
  endtask

  task automatic reset_and_check();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    chk("R8", pc_o, 0);
    chk("R8", acc_o, 0);
    chk("R8", ir_o, 0);
    rst = 0;
  endtask

  initial begin
    reset_and_check();
    drive_model(40);
    monitor(40);
    reset_and_check();
    drive_model(70);
    monitor(70);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule